// File: doc/BRIEF.md
# Vectored Interrupt Controller with Normal and Fast Request Lines

This block collects single-cycle event pulses from up to 26 peripheral sources and holds them in a pending register. It forwards any unmasked pending request to one of two active-low processor lines. A per-source steering bit picks the line: clear selects the normal line and set selects the fast line. One global mask bit silences both lines together.

Software reaches the block through a simple synchronous register bus. Writes are taken on the rising clock edge and reads are combinational from the address. Two service ports return the lowest-numbered pending source as a one-hot word, one port for the normal line and one for the fast line. Two clear ports remove pending bits with write-one-to-clear semantics. Four priority words are held for software but have no effect on arbitration.

Top module: `intc_vec`

## Requirements
- R1: After reset the register values are: control 0x7, enable mask 0x7FFFFFF, pending 0, steering 0, priority words 0x1B1B1B1B / 0x1F1B / 0x1B1B1B1B / 0x1B, and both request lines high.
- R2: The word addresses are: 0 control (3 bits), 1 pending (read-only), 2 steering, 3 enable mask (27 bits), 4–7 priority words (storage only), 8 normal service, 9 fast service, 10 normal clear, 11 fast clear.
- R3: While mask bit 26 is set, both request lines stay high whatever is pending.
- R4: When mask bit 26 is clear, a pending source whose own mask bit is clear drives fast_n low if its steering bit is 1, and irq_n low if its steering bit is 0. Each line reflects register state one clock after that state changes.
- R5: A source pulse sets its pending bit only when control bit 1 is 0, or when control bit 2 is 1 and control bit 0 is 0. Otherwise the pulse is dropped.
- R6: A read of address 8 returns the one-hot lowest set pending bit when control bit 1 is 0. It returns 0 otherwise.
- R7: A read of address 9 returns the one-hot lowest set pending bit when control bit 2 is 1 and control bit 0 is 0. It returns 0 otherwise.
- R8: A write to address 10 or 11 clears each pending bit whose data bit is 1. Data bits above 25 have no effect.
- R9: A write of the enable mask with bit 26 set forces the pending register to 0x1.
- R10: When a source pulse and a clear write hit the same bit in the same cycle, the bit stays set.
- R11: Addresses 12–15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_pulse | input | 26 | One-cycle event pulse for each source |
| irq_n | output | 1 | Normal request line, active low |
| fast_n | output | 1 | Fast request line, active low |

## Verification
A corrupted pending bit appears on the pending and service reads in the same cycle. It reaches a request line one clock later, but only if that bit is unmasked and the global mask is clear. A wrong steering or mask bit shows only as the wrong line falling one cycle after the change. For this reason the bench reads back every register it writes and then checks both lines after a single idle clock. A mistake in the acceptance gate appears as pending bits that are missing or extra on the very next pending read.

// File: rtl/intc_vec.sv
module intc_vec #(
  parameter int NSRC = 26,
  parameter int DW   = 32,
  parameter int AW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NSRC-1:0] src_pulse,
  output logic          irq_n,
  output logic          fast_n
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_PEND = AW'(1);
  localparam logic [AW-1:0] A_STEER = AW'(2);
  localparam logic [AW-1:0] A_MASK = AW'(3);
  localparam logic [AW-1:0] A_PR0  = AW'(4);
  localparam logic [AW-1:0] A_PR1  = AW'(5);
  localparam logic [AW-1:0] A_PR2  = AW'(6);
  localparam logic [AW-1:0] A_PR3  = AW'(7);
  localparam logic [AW-1:0] A_NSVC = AW'(8);
  localparam logic [AW-1:0] A_FSVC = AW'(9);
  localparam logic [AW-1:0] A_NCLR = AW'(10);
  localparam logic [AW-1:0] A_FCLR = AW'(11);
  localparam logic [NSRC-1:0] ONE = {{(NSRC-1){1'b0}}, 1'b1};

  logic [2:0]      ctrl_q;
  logic [NSRC-1:0] pend_q, pend_d, steer_q;
  logic [NSRC:0]   mask_q;
  logic [DW-1:0]   pr_q [4];
  logic [NSRC-1:0] low_bit, eff;
  logic            norm_en, fast_en, accept;

  assign norm_en = ~ctrl_q[1];
  assign fast_en = ctrl_q[2] & ~ctrl_q[0];
  assign accept  = norm_en | fast_en;
  assign low_bit = pend_q & (~pend_q + ONE);
  assign eff     = mask_q[NSRC] ? '0 : (pend_q & ~mask_q[NSRC-1:0]);

  wire wr_clr  = bus_we && (bus_addr == A_NCLR || bus_addr == A_FCLR);
  wire wr_mask = bus_we && bus_addr == A_MASK;

  always_comb begin
    pend_d = pend_q;
    if (wr_clr) pend_d = pend_d & ~bus_wdata[NSRC-1:0];
    if (wr_mask && bus_wdata[NSRC]) pend_d = ONE;
    if (accept) pend_d = pend_d | src_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= 3'h7;
      pend_q  <= '0;
      steer_q <= '0;
      mask_q  <= '1;
      pr_q[0] <= 32'h1B1B1B1B;
      pr_q[1] <= 32'h00001F1B;
      pr_q[2] <= 32'h1B1B1B1B;
      pr_q[3] <= 32'h0000001B;
      irq_n   <= 1'b1;
      fast_n  <= 1'b1;
    end else begin
      pend_q <= pend_d;
      irq_n  <= ~|(eff & ~steer_q);
      fast_n <= ~|(eff & steer_q);
      if (bus_we) begin
        case (bus_addr)
          A_CTRL:  ctrl_q  <= bus_wdata[2:0];
          A_STEER: steer_q <= bus_wdata[NSRC-1:0];
          A_MASK:  mask_q  <= bus_wdata[NSRC:0];
          A_PR0:   pr_q[0] <= bus_wdata;
          A_PR1:   pr_q[1] <= bus_wdata;
          A_PR2:   pr_q[2] <= bus_wdata;
          A_PR3:   pr_q[3] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = DW'(ctrl_q);
      A_PEND:  bus_rdata = DW'(pend_q);
      A_STEER: bus_rdata = DW'(steer_q);
      A_MASK:  bus_rdata = DW'(mask_q);
      A_PR0:   bus_rdata = pr_q[0];
      A_PR1:   bus_rdata = pr_q[1];
      A_PR2:   bus_rdata = pr_q[2];
      A_PR3:   bus_rdata = pr_q[3];
      A_NSVC:  bus_rdata = norm_en ? DW'(low_bit) : '0;
      A_FSVC:  bus_rdata = fast_en ? DW'(low_bit) : '0;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_vec_chk.sv
module intc_vec_chk #(
  parameter int NSRC = 26,
  parameter int AW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic [NSRC:0]   wdata_lo,
  input logic [NSRC-1:0] src_pulse,
  input logic [2:0]      ctrl_q,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] steer_q,
  input logic [NSRC:0]   mask_q,
  input logic [NSRC-1:0] low_bit,
  input logic            irq_n,
  input logic            fast_n
);
  wire acc = ~ctrl_q[1] | (ctrl_q[2] & ~ctrl_q[0]);
  wire [NSRC-1:0] live = pend_q & ~mask_q[NSRC-1:0];

  a_r3_gmask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_q[NSRC]) |-> (irq_n && fast_n));

  a_r4_fast_route: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mask_q[NSRC]) && $past((live & steer_q) != '0)) |-> !fast_n);

  a_r4_norm_route: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mask_q[NSRC]) && $past((live & ~steer_q) != '0)) |-> !irq_n);

  a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !bus_we) |=> ((pend_q & ~$past(pend_q)) == '0));

  a_r6_svc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(low_bit));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == AW'(10) || bus_addr == AW'(11)) && src_pulse == '0)
      |=> ((pend_q & $past(wdata_lo[NSRC-1:0])) == '0));

  a_r9_force: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(3) && wdata_lo[NSRC] && src_pulse == '0)
      |=> (pend_q == {{(NSRC-1){1'b0}}, 1'b1}));
endmodule

bind intc_vec intc_vec_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .wdata_lo(bus_wdata[NSRC:0]), .src_pulse(src_pulse), .ctrl_q(ctrl_q),
  .pend_q(pend_q), .steer_q(steer_q), .mask_q(mask_q), .low_bit(low_bit),
  .irq_n(irq_n), .fast_n(fast_n)
);

// File: tb/intc_vec_tb.sv
module intc_vec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [25:0] src_pulse = '0;
  logic        irq_n, fast_n;

  always #2 clk = ~clk;

  intc_vec u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pulse(src_pulse),
    .irq_n(irq_n), .fast_n(fast_n)
  );

  typedef struct {
    bit          lines;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = it.lines ? {30'b0, fast_n, irq_n} : bus_rdata;
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    it.lines = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic chk_lines(input logic [1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.lines = 1'b1; it.exp = {30'b0, e}; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr_pulse(input logic [3:0] a, input logic [31:0] d, input bit we,
                          input logic [25:0] p);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = we; src_pulse = p;
    @(posedge clk);
    #1 bus_we = 1'b0; src_pulse = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_pulse(a, d, 1'b1, '0);
  endtask

  task automatic pulse(input logic [25:0] p);
    wr_pulse(4'd0, 32'd0, 1'b0, p);
  endtask

  task automatic idle;
    @(posedge clk);
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rd(4'd0, 32'h7, "R1 control reset");
    rd(4'd3, 32'h7FFFFFF, "R1 mask reset");
    rd(4'd1, 32'h0, "R1 pending reset");
    rd(4'd2, 32'h0, "R1 steering reset");
    rd(4'd4, 32'h1B1B1B1B, "R1 prio0 reset");
    rd(4'd5, 32'h1F1B, "R1 prio1 reset");
    rd(4'd6, 32'h1B1B1B1B, "R1 prio2 reset");
    rd(4'd7, 32'h1B, "R1 prio3 reset");
    chk_lines(2'b11, "R1 lines reset");

    pulse(26'h8);
    rd(4'd1, 32'h0, "R5 dropped with control 7");

    wr(4'd0, 32'h0);
    rd(4'd0, 32'h0, "R2 control readback");
    pulse(26'h28);
    rd(4'd1, 32'h28, "R5 latched with control 0");
    idle;
    chk_lines(2'b11, "R3 all masked lines high");

    wr(4'd3, 32'h0);
    idle;
    chk_lines(2'b10, "R4 normal line low");
    rd(4'd8, 32'h8, "R6 normal service lowest");
    rd(4'd9, 32'h0, "R7 fast service disabled");

    wr(4'd2, 32'h8);
    rd(4'd2, 32'h8, "R2 steering readback");
    idle;
    chk_lines(2'b00, "R4 both lines low");

    wr(4'd3, 32'h20);
    idle;
    chk_lines(2'b01, "R4 fast only");

    wr(4'd3, 32'h4000000);
    rd(4'd1, 32'h1, "R9 pending forced to 1");
    idle;
    chk_lines(2'b11, "R3 global mask quiet");

    wr(4'd3, 32'h0);
    idle;
    chk_lines(2'b10, "R4 bit0 normal");

    wr(4'd10, 32'hFFFFFFFF);
    rd(4'd1, 32'h0, "R8 normal clear all");
    idle;
    chk_lines(2'b11, "R8 lines released");

    wr(4'd0, 32'h6);
    pulse(26'h100400);
    rd(4'd1, 32'h100400, "R5 latched fast enabled");
    rd(4'd8, 32'h0, "R6 normal service disabled");
    rd(4'd9, 32'h400, "R7 fast service lowest");
    wr(4'd11, 32'h400);
    rd(4'd1, 32'h100000, "R8 fast clear one bit");
    rd(4'd9, 32'h100000, "R7 fast service next");

    wr_pulse(4'd11, 32'h100000, 1'b1, 26'h100000);
    rd(4'd1, 32'h100000, "R10 set beats clear");

    wr(4'd15, 32'hFFFFFFFF);
    wr(4'd12, 32'hFFFFFFFF);
    rd(4'd15, 32'h0, "R11 unused reads zero");
    rd(4'd12, 32'h0, "R11 unused reads zero 12");
    rd(4'd0, 32'h6, "R11 control untouched");
    rd(4'd1, 32'h100000, "R11 pending untouched");

    wr(4'd0, 32'h3);
    pulse(26'h2);
    rd(4'd1, 32'h100000, "R5 dropped with control 3");

    wr(4'd5, 32'hA5A5A5A5);
    rd(4'd5, 32'hA5A5A5A5, "R2 prio word storage");

    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule